// File: doc/BRIEF.md
# Time-Multiplexed Multichannel Biquad Cascade

The block filters one frame of samples per channel through a cascade of second-order IIR sections. It has one arithmetic datapath for a direct-form-II biquad, and it runs that datapath over every section of every channel in turn. A multichannel front end can then apply a mains notch followed by a low-frequency high-pass to every channel without one filter per channel. All arithmetic is signed two's-complement fixed point, 64 bits wide, with 39 fraction bits and 25 integer bits.

The host loads the coefficients into an internal RAM through a single-word write port, so the response can change at run time. It also programs how many sections are active. When a frame arrives, the block takes the channels in ascending order. Each channel passes through sections 0 up to the last active section. The output of a section feeds the next section of the same channel. Every (channel, section) pair keeps its own two delay words across frames. Once the last channel has finished, all filtered samples appear together with a one-cycle done pulse. A synchronous clear input zeroes all delay state.

Top module: `mc_biquad_cascade`

## Requirements
- R1: The coefficient word for section s and slot k is written at address 5*s + k, where k = 0, 1, 2, 3, 4 selects b0, b1, b2, a1, a2 in that order. Writes to addresses at or above 5*NSEC change nothing.
- R2: Each section step computes w = x - P(a1,w1) - P(a2,w2), then y = P(b0,w) + P(b1,w1) + P(b2,w2). P(c,v) forms the full signed 128-bit product, shifts it arithmetically right by 39 and keeps the low 64 bits. All sums wrap modulo 2^64.
- R3: Section 0 receives the channel's input sample. Section s+1 receives the output of section s. The output of the last active section is the channel's result, placed at out_samples[64*c +: 64] for a channel c whose input is in_samples[64*c +: 64].
- R4: Every (channel, section) pair keeps its own w1 and w2. After a step of that pair, w2 takes the old w1 and w1 takes the new w. The state carries over from one frame to the next.
- R5: A high clr_state in a clock cycle sets every w1 and w2 to zero.
- R6: The active-section count resets to 1. A write of 0 stores 1, a write above NSEC stores NSEC, and any other value is stored as written. A frame uses the count that was stored when the frame was accepted.
- R7: in_valid starts a frame only while busy is low. Pulses of in_valid while busy is high are ignored and start no later frame.
- R8: busy rises at the accepting edge. done pulses high for exactly one cycle, 3*NCH*count clock edges after the accepting edge, and busy falls at that same edge. out_samples changes only at the edge that raises done.
- R9: Reset clears busy, done, out_samples, every coefficient and every delay word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_state | input | 1 | Synchronous clear of all delay state |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 6 | Coefficient address, 5*section + slot |
| coef_wdata | input | 64 | Coefficient value, Q25.39 |
| nsec_we | input | 1 | Active-section count write strobe |
| nsec_wdata | input | 4 | Requested section count |
| in_valid | input | 1 | New frame present on in_samples |
| in_samples | input | 512 | One Q25.39 sample per channel, channel c at bits 64*c+63 down to 64*c |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when out_samples is updated |
| out_samples | output | 512 | Filtered sample per channel, same packing as the input |

## Verification
The bench sweeps the active-section count from 1 to 8 with mixed-sign coefficients over several consecutive frames. A design that shares delay state between pairs, does not carry it over from one frame to the next, or takes the wrong channel order or section chaining would drift away from the arithmetic model within a frame or two. It writes count values of 0 and 15 and measures the frame length, which exposes a missing clamp. It drives products that overflow, which catch unsigned multiplication or a saturating sum. It pulses in_valid during a frame and writes out-of-range coefficient addresses, then checks that no extra done pulse appears and that no result moves. It checks the outputs against the model after a clear, which reveals a clear that leaves delay state behind.

// File: rtl/mbq_pkg.sv
package mbq_pkg;

   localparam int COEF_PER_SEC = 5;

   typedef enum logic [2:0] {
      K_B0 = 3'd0,
      K_B1 = 3'd1,
      K_B2 = 3'd2,
      K_A1 = 3'd3,
      K_A2 = 3'd4
   } coef_slot_e;

endpackage

// File: rtl/mbq_coef_ram.sv
module mbq_coef_ram
   import mbq_pkg::*;
#(
   parameter int NSEC = 8,
   parameter int DW   = 64,
   localparam int NW  = COEF_PER_SEC * NSEC,
   localparam int AW  = $clog2(NW),
   localparam int SW  = $clog2(NSEC)
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [AW-1:0]                      wr_addr,
   input  logic [DW-1:0]                      wr_data,
   input  logic [SW-1:0]                      rd_sec,
   output logic [COEF_PER_SEC-1:0][DW-1:0]    rd_coef
);

   logic [DW-1:0] mem [NW];
   logic [AW-1:0] base;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NW; i++) mem[i] <= '0;
      end else if (wr_en && (int'(wr_addr) < NW)) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign base = AW'(rd_sec) * AW'(COEF_PER_SEC);

   for (genvar k = 0; k < COEF_PER_SEC; k++) begin : g_rd
      assign rd_coef[k] = mem[base + AW'(k)];
   end

endmodule

// File: rtl/mbq_state_bank.sv
module mbq_state_bank #(
   parameter int NCH  = 8,
   parameter int NSEC = 8,
   parameter int DW   = 64,
   localparam int NE  = NCH * NSEC,
   localparam int EW  = $clog2(NE),
   localparam int CHW = $clog2(NCH),
   localparam int SW  = $clog2(NSEC)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           upd,
   input  logic [CHW-1:0] sel_ch,
   input  logic [SW-1:0]  sel_sec,
   input  logic [DW-1:0]  w_new,
   output logic [DW-1:0]  w1,
   output logic [DW-1:0]  w2
);

   logic [DW-1:0] d1 [NE];
   logic [DW-1:0] d2 [NE];
   logic [EW-1:0] idx;

   assign idx = EW'(sel_ch) * EW'(NSEC) + EW'(sel_sec);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         for (int i = 0; i < NE; i++) begin
            d1[i] <= '0;
            d2[i] <= '0;
         end
      end else if (upd) begin
         d2[idx] <= d1[idx];
         d1[idx] <= w_new;
      end
   end

   assign w1 = d1[idx];
   assign w2 = d2[idx];

endmodule

// File: rtl/mbq_core.sv
module mbq_core
   import mbq_pkg::*;
#(
   parameter int DW   = 64,
   parameter int FRAC = 39,
   parameter int PIPE = 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            go,
   input  logic [DW-1:0]                   x,
   input  logic [COEF_PER_SEC-1:0][DW-1:0] coef,
   input  logic [DW-1:0]                   w1,
   input  logic [DW-1:0]                   w2,
   output logic                            res_vld,
   output logic [DW-1:0]                   w_out,
   output logic [DW-1:0]                   y_out
);

   function automatic logic [DW-1:0] fx_mul(input logic [DW-1:0] c, input logic [DW-1:0] v);
      logic signed [2*DW-1:0] p;
      p = $signed({{DW{c[DW-1]}}, c}) * $signed({{DW{v[DW-1]}}, v});
      return p[FRAC+DW-1:FRAC];
   endfunction

   logic [DW-1:0] w_c;
   logic [DW-1:0] w_use;
   logic          y_go;

   assign w_c = x - fx_mul(coef[K_A1], w1) - fx_mul(coef[K_A2], w2);

   if (PIPE == 0) begin : g_single
      assign w_use = w_c;
      assign y_go  = go;
   end else begin : g_split
      logic [DW-1:0] w_q;
      logic          v_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            w_q <= '0;
            v_q <= 1'b0;
         end else begin
            v_q <= go;
            if (go) w_q <= w_c;
         end
      end
      assign w_use = w_q;
      assign y_go  = v_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_vld <= 1'b0;
         w_out   <= '0;
         y_out   <= '0;
      end else begin
         res_vld <= y_go;
         if (y_go) begin
            w_out <= w_use;
            y_out <= fx_mul(coef[K_B0], w_use) + fx_mul(coef[K_B1], w1)
                   + fx_mul(coef[K_B2], w2);
         end
      end
   end

endmodule

// File: rtl/mc_biquad_cascade.sv
module mc_biquad_cascade
   import mbq_pkg::*;
#(
   parameter int NCH   = 8,
   parameter int NSEC  = 8,
   parameter int DW    = 64,
   parameter int FRAC  = 39,
   parameter int PIPE  = 1,
   localparam int CHW  = $clog2(NCH),
   localparam int SW   = $clog2(NSEC),
   localparam int CNTW = $clog2(NSEC + 1),
   localparam int AW   = $clog2(COEF_PER_SEC * NSEC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_state,
   input  logic              coef_we,
   input  logic [AW-1:0]     coef_addr,
   input  logic [DW-1:0]     coef_wdata,
   input  logic              nsec_we,
   input  logic [CNTW-1:0]   nsec_wdata,
   input  logic              in_valid,
   input  logic [NCH*DW-1:0] in_samples,
   output logic              busy,
   output logic              done,
   output logic [NCH*DW-1:0] out_samples
);

   if (NCH < 2) begin : g_chk_nch
      $error("mc_biquad_cascade: NCH must be at least 2");
   end
   if (NSEC < 2) begin : g_chk_nsec
      $error("mc_biquad_cascade: NSEC must be at least 2");
   end
   if (FRAC < 1 || FRAC >= DW) begin : g_chk_frac
      $error("mc_biquad_cascade: FRAC must lie in 1..DW-1");
   end
   if (PIPE < 0 || PIPE > 1) begin : g_chk_pipe
      $error("mc_biquad_cascade: PIPE must be 0 or 1");
   end

   logic [CNTW-1:0]                 cnt_q;
   logic                            run_q;
   logic                            done_q;
   logic                            wait_q;
   logic [CHW-1:0]                  ch_q;
   logic [SW-1:0]                   sec_q;
   logic [SW-1:0]                   last_q;
   logic [DW-1:0]                   x_q;
   logic [NCH-1:0][DW-1:0]          in_q;
   logic [NCH-1:0][DW-1:0]          res_q;
   logic [NCH-1:0][DW-1:0]          out_q;

   logic                            go;
   logic                            res_vld;
   logic [DW-1:0]                   w_res;
   logic [DW-1:0]                   y_res;
   logic [DW-1:0]                   w1;
   logic [DW-1:0]                   w2;
   logic [COEF_PER_SEC-1:0][DW-1:0] coef;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= CNTW'(1);
      end else if (nsec_we) begin
         if (nsec_wdata == '0)
            cnt_q <= CNTW'(1);
         else if (int'(nsec_wdata) > NSEC)
            cnt_q <= CNTW'(NSEC);
         else
            cnt_q <= nsec_wdata;
      end
   end

   mbq_coef_ram #(.NSEC(NSEC), .DW(DW)) u_coef (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (coef_we),
      .wr_addr (coef_addr),
      .wr_data (coef_wdata),
      .rd_sec  (sec_q),
      .rd_coef (coef)
   );

   mbq_state_bank #(.NCH(NCH), .NSEC(NSEC), .DW(DW)) u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr_state),
      .upd     (res_vld),
      .sel_ch  (ch_q),
      .sel_sec (sec_q),
      .w_new   (w_res),
      .w1      (w1),
      .w2      (w2)
   );

   mbq_core #(.DW(DW), .FRAC(FRAC), .PIPE(PIPE)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go),
      .x       (x_q),
      .coef    (coef),
      .w1      (w1),
      .w2      (w2),
      .res_vld (res_vld),
      .w_out   (w_res),
      .y_out   (y_res)
   );

   assign go = run_q && !wait_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         done_q <= 1'b0;
         wait_q <= 1'b0;
         ch_q   <= '0;
         sec_q  <= '0;
         last_q <= '0;
         x_q    <= '0;
         in_q   <= '0;
         res_q  <= '0;
         out_q  <= '0;
      end else begin
         done_q <= 1'b0;
         wait_q <= (wait_q || go) && !res_vld;
         if (!run_q) begin
            if (in_valid) begin
               run_q  <= 1'b1;
               in_q   <= in_samples;
               x_q    <= in_samples[DW-1:0];
               ch_q   <= '0;
               sec_q  <= '0;
               last_q <= SW'(cnt_q - CNTW'(1));
            end
         end else if (res_vld) begin
            if (sec_q == last_q) begin
               res_q[ch_q] <= y_res;
               if (ch_q == CHW'(NCH - 1)) begin
                  run_q  <= 1'b0;
                  done_q <= 1'b1;
                  for (int c = 0; c < NCH - 1; c++) out_q[c] <= res_q[c];
                  out_q[NCH-1] <= y_res;
               end else begin
                  ch_q  <= ch_q + CHW'(1);
                  sec_q <= '0;
                  x_q   <= in_q[ch_q + CHW'(1)];
               end
            end else begin
               sec_q <= sec_q + SW'(1);
               x_q   <= y_res;
            end
         end
      end
   end

   assign busy        = run_q;
   assign done        = done_q;
   assign out_samples = out_q;

endmodule

// File: rtl/mbq_checker.sv
module mbq_checker #(
   parameter int NCH  = 8,
   parameter int NSEC = 8,
   parameter int DW   = 64,
   parameter int CNTW = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              in_valid,
   input logic [NCH*DW-1:0] out_samples,
   input logic [CNTW-1:0]   cnt_q
);

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_falls_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_out_only_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(out_samples));

   assert_accept_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && in_valid) |=> busy);

   assert_count_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cnt_q) >= 1) && (int'(cnt_q) <= NSEC));

endmodule

bind mc_biquad_cascade mbq_checker #(
   .NCH(NCH), .NSEC(NSEC), .DW(DW), .CNTW(CNTW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy        (busy),
   .done        (done),
   .in_valid    (in_valid),
   .out_samples (out_samples),
   .cnt_q       (cnt_q)
);

// File: tb/tb_mc_biquad_cascade.sv
module tb_mc_biquad_cascade;

   localparam int NCH  = 8;
   localparam int NSEC = 8;
   localparam int DW   = 64;
   localparam int STEP = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              clr_state = 1'b0;
   logic              coef_we = 1'b0;
   logic [5:0]        coef_addr = '0;
   logic [DW-1:0]     coef_wdata = '0;
   logic              nsec_we = 1'b0;
   logic [3:0]        nsec_wdata = '0;
   logic              in_valid = 1'b0;
   logic [NCH*DW-1:0] in_samples = '0;
   logic              busy;
   logic              done;
   logic [NCH*DW-1:0] out_samples;

   int total = 0;
   int bad = 0;

   logic signed [63:0] mc [NSEC][5];
   logic signed [63:0] ms1 [NCH][NSEC];
   logic signed [63:0] ms2 [NCH][NSEC];
   logic signed [63:0] xin [NCH];
   logic signed [63:0] yexp [NCH];
   int                 mcnt;
   logic [63:0]        seed = 64'h1234_5678_9abc_def1;

   always #2.5 clk = ~clk;

   mc_biquad_cascade dut (
      .clk(clk), .rst_n(rst_n), .clr_state(clr_state),
      .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata),
      .nsec_we(nsec_we), .nsec_wdata(nsec_wdata),
      .in_valid(in_valid), .in_samples(in_samples),
      .busy(busy), .done(done), .out_samples(out_samples)
   );

   initial begin
      #(200000 * 5);
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   function automatic logic signed [63:0] pmul(input logic signed [63:0] a, input logic signed [63:0] b);
      logic signed [127:0] p;
      p = a * b;
      return p[102:39];
   endfunction

   function automatic logic [63:0] rnd();
      seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
      return seed;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total = total + 1;
      if (act !== exp) begin
         bad = bad + 1;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_coef(input int addr, input logic [63:0] v);
      @(negedge clk);
      coef_we = 1'b1; coef_addr = 6'(addr); coef_wdata = v;
      @(negedge clk);
      coef_we = 1'b0;
      if (addr < 5 * NSEC) mc[addr / 5][addr % 5] = v;
   endtask

   task automatic set_cnt(input int v);
      @(negedge clk);
      nsec_we = 1'b1; nsec_wdata = 4'(v);
      @(negedge clk);
      nsec_we = 1'b0;
      mcnt = (v == 0) ? 1 : ((v > NSEC) ? NSEC : v);
   endtask

   task automatic do_clear();
      @(negedge clk);
      clr_state = 1'b1;
      @(negedge clk);
      clr_state = 1'b0;
      for (int c = 0; c < NCH; c++)
         for (int s = 0; s < NSEC; s++) begin
            ms1[c][s] = 0; ms2[c][s] = 0;
         end
   endtask

   task automatic model_frame();
      for (int c = 0; c < NCH; c++) begin
         logic signed [63:0] x, w, y;
         x = xin[c];
         for (int s = 0; s < mcnt; s++) begin
            w = x - pmul(mc[s][3], ms1[c][s]) - pmul(mc[s][4], ms2[c][s]);
            y = pmul(mc[s][0], w) + pmul(mc[s][1], ms1[c][s]) + pmul(mc[s][2], ms2[c][s]);
            ms2[c][s] = ms1[c][s];
            ms1[c][s] = w;
            x = y;
         end
         yexp[c] = x;
      end
   endtask

   task automatic run_frame(input string req, input int junk_at);
      int n;
      for (int c = 0; c < NCH; c++) in_samples[c*64 +: 64] = xin[c];
      model_frame();
      @(negedge clk);
      in_valid = 1'b1;
      n = 0;
      do begin
         @(posedge clk);
         n = n + 1;
         @(negedge clk);
         in_valid = (junk_at > 0 && n == junk_at) ? 1'b1 : 1'b0;
         if (in_valid) in_samples = {NCH{rnd()}};
      end while (!done && n < 1000);
      in_valid = 1'b0;
      chk({req, " R8 latency"}, 64'(n), 64'(STEP * NCH * mcnt + 1));
      chk({req, " R8 busy low at done"}, 64'(busy), 64'd0);
      for (int c = 0; c < NCH; c++) chk({req, " R2 R3 output"}, out_samples[c*64 +: 64], yexp[c]);
      @(negedge clk);
      chk({req, " R8 done single pulse"}, 64'(done), 64'd0);
   endtask

   task automatic rnd_inputs(input int mag);
      for (int c = 0; c < NCH; c++) begin
         logic [63:0] r;
         r = rnd();
         xin[c] = $signed(r) >>> mag;
      end
   endtask

   task automatic rnd_coefs();
      for (int a = 0; a < 5 * NSEC; a++) begin
         logic [63:0] r;
         r = rnd();
         wr_coef(a, $signed(r) >>> 26);
      end
   endtask

   initial begin
      mcnt = 1;
      for (int s = 0; s < NSEC; s++) for (int k = 0; k < 5; k++) mc[s][k] = 0;
      for (int c = 0; c < NCH; c++)
         for (int s = 0; s < NSEC; s++) begin
            ms1[c][s] = 0; ms2[c][s] = 0;
         end
      repeat (3) @(negedge clk);
      chk("R9 busy in reset", 64'(busy), 64'd0);
      chk("R9 done in reset", 64'(done), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 busy after reset", 64'(busy), 64'd0);
      for (int c = 0; c < NCH; c++) chk("R9 outputs after reset", out_samples[c*64 +: 64], 64'd0);

      // R9: zero coefficients and count 1 after reset
      rnd_inputs(10);
      run_frame("R9 zero coefs", 0);

      // R5: clear then random coefficients, sweep every count (R1 R4 R6)
      do_clear();
      rnd_coefs();
      for (int k = 1; k <= NSEC; k++) begin
         set_cnt(k);
         for (int f = 0; f < 3; f++) begin
            rnd_inputs(12);
            run_frame("R3 R4 count sweep", 0);
         end
      end

      // R5: clear restores zero state mid-stream
      do_clear();
      set_cnt(3);
      rnd_inputs(8);
      run_frame("R5 after clear", 0);

      // R6: clamps
      set_cnt(0);
      rnd_inputs(12);
      run_frame("R6 zero written", 0);
      set_cnt(15);
      rnd_inputs(12);
      run_frame("R6 above max written", 0);

      // R1: out-of-range addresses change nothing
      for (int a = 5 * NSEC; a < 64; a++) begin
         @(negedge clk);
         coef_we = 1'b1; coef_addr = 6'(a); coef_wdata = 64'h7fff_0000_1234_5678;
         @(negedge clk);
         coef_we = 1'b0;
      end
      set_cnt(NSEC);
      rnd_inputs(12);
      run_frame("R1 bad address ignored", 0);

      // R7: in_valid while busy ignored
      set_cnt(2);
      rnd_inputs(12);
      run_frame("R7 busy pulse", 10);
      begin
         logic [NCH*DW-1:0] held;
         logic seen;
         held = out_samples;
         seen = 1'b0;
         for (int i = 0; i < STEP * NCH * 2 + 20; i++) begin
            @(negedge clk);
            if (done || busy) seen = 1'b1;
         end
         chk("R7 no extra frame", 64'(seen), 64'd0);
         chk("R7 outputs held", 64'(out_samples == held), 64'd1);
      end

      // R2: wrap on overflow and signed products
      do_clear();
      for (int a = 0; a < 5 * NSEC; a++) wr_coef(a, 64'd0);
      wr_coef(0, 64'sd1 <<< 40);
      wr_coef(1, -(64'sd1 <<< 38));
      set_cnt(1);
      for (int c = 0; c < NCH; c++) xin[c] = (c % 2 == 0) ? (64'sd1 <<< 62) + 64'(c) : -(64'sd3 <<< 60);
      run_frame("R2 wrap", 0);
      for (int c = 0; c < NCH; c++) xin[c] = -(64'sd5 <<< 39) + 64'(c);
      run_frame("R2 signed state", 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule